// File: doc/BRIEF.md
# DRAM Timing Cycle Converter

This block turns DRAM timing minimums, each given as a time in picoseconds, into whole numbers of clock cycles of the clock the controller really drives to the memory. Counts do not follow the nominal period of the part's speed grade. The controller supplies its clock period and a jitter allowance. The effective period is the clock period minus that allowance. Every timing minimum is divided by the effective period and the result is rounded up. Some parameters are specified as "the greater of N clocks or T time". For those, the time-derived count is raised to the cycle floor N when N is larger.

The block uses the same arithmetic to pick the read latency. It takes the smallest latency whose total time covers the device access time, clamped to a legal window. It raises an error flag when even the largest legal latency is too short. A single shared sequential divider does the work, one entry after another. It starts over whenever the period or the jitter input changes.

Each table entry also drives a countdown timer. A start strobe loads the entry's cycle count into the timer. The entry's ready flag returns once that many clocks have passed. The sequencing logic of the controller uses these flags to space its commands.

Top module: `dram_cycle_conv`

## Requirements
- R1: With E = period_ps − jitter_ps, each entry's count is max(floor, max(1, ceil(T / E))), where entry i takes its time T from min_time_ps[i*20 +: 20] and its floor from min_cyc[i*8 +: 8], and writes its count to cyc_count[i*8 +: 8].
- R2: The division rounds up and never truncates. 13500 ps at a 3333 ps clock gives 5. A time that is an exact multiple of E gives exactly T / E, so 9375 ps at 1875 ps gives 5.
- R3: When the cycle floor is larger than the time-derived count, the floor is the result. 5000 ps with a floor of 3 at a 3333 ps clock gives 3.
- R4: A time-derived value of zero counts as 1 cycle. A floor of 0 means the entry has no cycle floor.
- R5: The jitter allowance shortens the effective period. When jitter_ps ≥ period_ps, the effective period is 1 ps.
- R6: rd_lat is the smallest L with L × E ≥ access_ps, clamped to [LAT_MIN, LAT_MAX] (defaults 3 and 14). 9375 ps at 3200 ps gives 3.
- R7: When ceil(access_ps / E) exceeds LAT_MAX, lat_err is 1 and rd_lat equals LAT_MAX. Otherwise lat_err is 0.
- R8: A count that does not fit in 8 bits saturates to 255.
- R9: A change of period_ps or jitter_ps drops valid and raises busy at the first clock edge that samples it. busy and valid are never high together. A change during a recalculation restarts it, so the results reflect the latest inputs.
- R10: While valid is high, a strobe on start[i] sampled at edge k drives ready[i] low. ready[i] returns high after edge k + C, where C is the entry's count.
- R11: A new strobe while a timer is running restarts the timer from the full count.
- R12: ready is all zero while valid is low. Timers are cleared and strobes are ignored then, so every ready flag is high as soon as valid returns.
- R13: During reset, valid, busy and ready are 0. A first calculation starts by itself once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_ps | input | 16 | Period of the clock driven to the memory, ps |
| jitter_ps | input | 16 | Jitter allowance subtracted from the period, ps |
| access_ps | input | 20 | Device access time the read latency must cover, ps |
| min_time_ps | input | 80 | Four 20-bit minimum times, entry i at bits i*20 |
| min_cyc | input | 32 | Four 8-bit cycle floors, entry i at bits i*8 |
| start | input | 4 | Per-entry timer start strobes |
| busy | output | 1 | Recalculation in progress |
| valid | output | 1 | Counts and latency are current |
| cyc_count | output | 32 | Four 8-bit cycle counts, entry i at bits i*8 |
| rd_lat | output | 8 | Selected read latency in cycles |
| lat_err | output | 1 | Access time cannot be met at LAT_MAX |
| ready | output | 4 | Per-entry timer expired |

## Verification
A full recalculation takes five divisions of 23 clock edges each, starting at the edge after a period or jitter change. The scoreboard therefore pops and compares when valid rises, not after a fixed delay. One falling edge after the changed input is driven, the bench checks valid low and busy high, because that edge sample follows the first rising edge that sees the change. Timer checks sample ready at every falling edge after the strobe edge. ready must stay low for exactly C samples and must be high at sample C + 1, and a restrobe moves that point forward by the full count again.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int DTC_CNT_W   = 8;
    localparam int DTC_CNT_MAX = (1 << DTC_CNT_W) - 1;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_LOAD,
        CS_WAIT
    } calc_state_e;

    typedef struct packed {
        logic [DTC_CNT_W-1:0] lat;
        logic                 err;
    } lat_res_t;

    // Time-derived count (zero forced to one, saturated), then raised to the floor.
    function automatic logic [DTC_CNT_W-1:0] dtc_time_cnt(
        input logic [31:0]          q,
        input logic [DTC_CNT_W-1:0] flr
    );
        logic [DTC_CNT_W-1:0] t;
        if (q == 32'd0)
            t = DTC_CNT_W'(1);
        else if (q > 32'(DTC_CNT_MAX))
            t = '1;
        else
            t = q[DTC_CNT_W-1:0];
        return (flr > t) ? flr : t;
    endfunction

    // Smallest latency covering the access time, clamped to the legal window.
    function automatic lat_res_t dtc_pick_lat(
        input logic [31:0] q,
        input int          lo,
        input int          hi
    );
        lat_res_t r;
        r.err = (q > 32'(hi));
        if (q < 32'(lo))
            r.lat = DTC_CNT_W'(lo);
        else if (r.err)
            r.lat = DTC_CNT_W'(hi);
        else
            r.lat = q[DTC_CNT_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/dtc_ceil_div.sv
module dtc_ceil_div #(
    parameter int NW = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [NW-1:0] num,
    input  logic [NW-1:0] den,
    output logic        done,
    output logic [NW:0] quo
);
    localparam int W    = NW + 1;
    localparam int CNTW = $clog2(W + 1);

    logic [W-1:0]    dvd;
    logic [W-1:0]    rem;
    logic [W:0]      trial;
    logic [W:0]      den_x;
    logic [CNTW-1:0] left;
    logic            run;

    assign trial = {rem, dvd[W-1]};
    assign den_x = {2'b00, den};
    assign quo   = dvd;

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd  <= '0;
            rem  <= '0;
            left <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else if (start) begin
            // ceil(num/den) = floor((num + den - 1) / den), den >= 1
            dvd  <= {1'b0, num} + {1'b0, den} - W'(1);
            rem  <= '0;
            left <= CNTW'(W);
            run  <= 1'b1;
            done <= 1'b0;
        end else if (run) begin
            if (trial >= den_x) begin
                rem <= W'(trial - den_x);
                dvd <= {dvd[W-2:0], 1'b1};
            end else begin
                rem <= trial[W-1:0];
                dvd <= {dvd[W-2:0], 1'b0};
            end
            left <= left - CNTW'(1);
            if (left == CNTW'(1)) begin
                run  <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R9: the completion handshake is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: the divider stays idle while it reports completion
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !run);

endmodule

// File: rtl/dtc_countdown.sv
module dtc_countdown
    import dtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 start,
    input  logic [DTC_CNT_W-1:0] load,
    output logic                 zero
);
    logic [DTC_CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (start)
            cnt <= load;
        else if (cnt != '0)
            cnt <= cnt - DTC_CNT_W'(1);
    end

    assign zero = (cnt == '0);

    // R10, R11: a strobe (also mid-count) loads the full count
    p_load_r11: assert property (@(posedge clk) disable iff (rst)
        (en && start) |=> (cnt == $past(load)));

    // R10: a running timer moves down by exactly one per clock
    p_step_r10: assert property (@(posedge clk) disable iff (rst)
        (en && !start && cnt != '0) |=> (cnt == $past(cnt) - DTC_CNT_W'(1)));

    // R12: strobes are ignored while results are stale
    p_cleared_r12: assert property (@(posedge clk) disable iff (rst)
        !en |=> zero);

endmodule

// File: rtl/dram_cycle_conv.sv
module dram_cycle_conv
    import dtc_pkg::*;
#(
    parameter int NPARAM  = 4,
    parameter int TW      = 20,
    parameter int PW      = 16,
    parameter int LAT_MIN = 3,
    parameter int LAT_MAX = 14
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [PW-1:0]                 period_ps,
    input  logic [PW-1:0]                 jitter_ps,
    input  logic [TW-1:0]                 access_ps,
    input  logic [NPARAM*TW-1:0]          min_time_ps,
    input  logic [NPARAM*DTC_CNT_W-1:0]   min_cyc,
    input  logic [NPARAM-1:0]             start,
    output logic                          busy,
    output logic                          valid,
    output logic [NPARAM*DTC_CNT_W-1:0]   cyc_count,
    output logic [DTC_CNT_W-1:0]          rd_lat,
    output logic                          lat_err,
    output logic [NPARAM-1:0]             ready
);
    localparam int CW = DTC_CNT_W;
    localparam int IW = $clog2(NPARAM + 1);

    calc_state_e         st;
    logic [IW-1:0]       idx;
    logic                kick;
    logic [PW-1:0]       prev_p;
    logic [PW-1:0]       prev_j;
    logic                chg;
    logic [PW-1:0]       eff;
    logic [TW-1:0]       den;
    logic [TW-1:0]       num;
    logic [CW-1:0]       flr;
    logic                div_done;
    logic [TW:0]         div_quo;
    logic [CW-1:0]       cyc_q [NPARAM];
    lat_res_t            lat_q;
    lat_res_t            lat_new;
    logic [NPARAM-1:0]   tmr_zero;

    // Effective period: nominal minus jitter allowance, never below 1 ps
    assign eff = (jitter_ps >= period_ps) ? PW'(1) : (period_ps - jitter_ps);
    assign den = TW'(eff);
    assign chg = (period_ps != prev_p) || (jitter_ps != prev_j);

    // Operand select: entries first, access time last
    always_comb begin
        num = access_ps;
        flr = '0;
        for (int i = 0; i < NPARAM; i++) begin
            if (idx == IW'(i)) begin
                num = min_time_ps[i*TW +: TW];
                flr = min_cyc[i*CW +: CW];
            end
        end
    end

    assign lat_new = dtc_pick_lat(32'(div_quo), LAT_MIN, LAT_MAX);

    dtc_ceil_div #(.NW(TW)) div_i (
        .clk   (clk),
        .rst   (rst),
        .start (st == CS_LOAD),
        .num   (num),
        .den   (den),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= CS_IDLE;
            idx    <= '0;
            kick   <= 1'b1;
            valid  <= 1'b0;
            prev_p <= '0;
            prev_j <= '0;
            lat_q  <= '{lat: CW'(LAT_MIN), err: 1'b0};
            for (int i = 0; i < NPARAM; i++) cyc_q[i] <= '0;
        end else begin
            prev_p <= period_ps;
            prev_j <= jitter_ps;
            kick   <= 1'b0;
            if (kick || chg) begin
                st    <= CS_LOAD;
                idx   <= '0;
                valid <= 1'b0;
            end else begin
                case (st)
                    CS_LOAD: st <= CS_WAIT;
                    CS_WAIT: begin
                        if (div_done) begin
                            if (idx == IW'(NPARAM)) begin
                                lat_q <= lat_new;
                                valid <= 1'b1;
                                st    <= CS_IDLE;
                            end else begin
                                for (int i = 0; i < NPARAM; i++)
                                    if (idx == IW'(i))
                                        cyc_q[i] <= dtc_time_cnt(32'(div_quo), flr);
                                idx <= idx + IW'(1);
                                st  <= CS_LOAD;
                            end
                        end
                    end
                    default: st <= CS_IDLE;
                endcase
            end
        end
    end

    assign busy    = (st != CS_IDLE);
    assign rd_lat  = lat_q.lat;
    assign lat_err = lat_q.err;

    generate
        for (genvar g = 0; g < NPARAM; g++) begin : g_entry
            assign cyc_count[g*CW +: CW] = cyc_q[g];

            dtc_countdown tmr_i (
                .clk   (clk),
                .rst   (rst),
                .en    (valid),
                .start (start[g]),
                .load  (cyc_q[g]),
                .zero  (tmr_zero[g])
            );

            assign ready[g] = valid && tmr_zero[g];

            // R3, R4: a stored count honours its floor and is never zero
            p_floor_r3: assert property (@(posedge clk) disable iff (rst)
                (st == CS_WAIT && div_done && !chg && !kick && idx == IW'(g))
                |=> (cyc_q[g] >= $past(min_cyc[g*CW +: CW])) && (cyc_q[g] != '0));
        end
    endgenerate

    // R9: handshake flags are exclusive
    p_busy_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !(busy && valid));

    // R9: an input change always invalidates the results
    p_change_drop_r9: assert property (@(posedge clk) disable iff (rst)
        chg |=> (!valid && busy));

    // R12: no timer reports ready while results are stale
    p_ready_stale_r12: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (ready == '0));

    // R6: reported latency stays inside the legal window
    p_lat_window_r6: assert property (@(posedge clk) disable iff (rst)
        valid |-> (rd_lat >= CW'(LAT_MIN) && rd_lat <= CW'(LAT_MAX)));

    // R7: an unmeetable access time pins the latency at the top
    p_lat_err_r7: assert property (@(posedge clk) disable iff (rst)
        (valid && lat_err) |-> (rd_lat == CW'(LAT_MAX)));

    // R2: the divider result is the exact ceiling of the operands
    p_ceiling_r2: assert property (@(posedge clk) disable iff (rst)
        (st == CS_WAIT && div_done && !chg)
        |-> ((64'(div_quo) * 64'(den) >= 64'(num)) &&
             (div_quo == '0 || (64'(div_quo) - 64'd1) * 64'(den) < 64'(num))));

endmodule

// File: tb/dram_cycle_conv_tb_top.sv
module dram_cycle_conv_tb_top;

    localparam int NP = 4;

    typedef struct packed {
        logic [NP-1:0][7:0] cnt;
        logic [7:0]         lat;
        logic               err;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst;
    logic [15:0]      period_ps;
    logic [15:0]      jitter_ps;
    logic [19:0]      access_ps;
    logic [NP*20-1:0] min_time_ps;
    logic [NP*8-1:0]  min_cyc;
    logic [NP-1:0]    start;
    logic             busy;
    logic             valid;
    logic [NP*8-1:0]  cyc_count;
    logic [7:0]       rd_lat;
    logic             lat_err;
    logic [NP-1:0]    ready;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done_f = 1'b0;
    bit   valid_q = 1'b0;
    exp_t sb_q[$];

    int tt[NP] = '{13500, 5000, 0, 15000};
    int ff[NP] = '{0, 3, 0, 4};
    localparam int ACC = 9375;

    always #4 clk = ~clk;

    dram_cycle_conv dut_i (
        .clk         (clk),
        .rst         (rst),
        .period_ps   (period_ps),
        .jitter_ps   (jitter_ps),
        .access_ps   (access_ps),
        .min_time_ps (min_time_ps),
        .min_cyc     (min_cyc),
        .start       (start),
        .busy        (busy),
        .valid       (valid),
        .cyc_count   (cyc_count),
        .rd_lat      (rd_lat),
        .lat_err     (lat_err),
        .ready       (ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic exp_t model(input int per, input int jit);
        exp_t e;
        int   eff;
        int   q;
        eff = (jit >= per) ? 1 : per - jit;                    // R5
        for (int i = 0; i < NP; i++) begin
            q = (tt[i] + eff - 1) / eff;                        // R1, R2
            if (q == 0) q = 1;                                  // R4
            if (q > 255) q = 255;                               // R8
            if (ff[i] > q) q = ff[i];                           // R3
            e.cnt[i] = 8'(q);
        end
        q = (ACC + eff - 1) / eff;                              // R6
        e.err = (q > 14);                                       // R7
        e.lat = (q < 3) ? 8'd3 : (q > 14) ? 8'd14 : 8'(q);
        return e;
    endfunction

    // Monitor: compare when a fresh result set appears
    always @(negedge clk) begin
        if (!rst) begin
            if (valid && !valid_q) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected result set", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    for (int i = 0; i < NP; i++)
                        chk(cyc_count[i*8 +: 8] == e.cnt[i], $sformatf("R1 count entry %0d", i),
                            cyc_count[i*8 +: 8], e.cnt[i]);
                    chk(rd_lat == e.lat, "R6 latency", rd_lat, e.lat);
                    chk(lat_err == e.err, "R7 error flag", lat_err, e.err);
                    chk(busy == 1'b0, "R9 busy at valid", busy, 0);
                end
            end
            valid_q = valid;
        end
    end

    task automatic wait_valid();
        while (!valid) @(negedge clk);
        @(negedge clk);
    endtask

    // Driver: push the expected set, change the clock inputs
    task automatic apply(input int per, input int jit, input bit push);
        @(negedge clk);
        if (push) sb_q.push_back(model(per, jit));
        period_ps = 16'(per);
        jitter_ps = 16'(jit);
        @(negedge clk);
        chk(valid == 1'b0, "R9 valid drops", valid, 0);
        chk(busy == 1'b1, "R9 busy rises", busy, 1);
    endtask

    task automatic strobe_run(input int i, input int c, input string req);
        @(negedge clk);
        start[i] = 1'b1;
        @(negedge clk);
        start[i] = 1'b0;
        chk(ready[i] == 1'b0, req, ready[i], 0);
        for (int k = 1; k < c; k++) begin
            @(negedge clk);
            chk(ready[i] == 1'b0, req, ready[i], 0);
        end
        @(negedge clk);
        chk(ready[i] == 1'b1, req, ready[i], 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_f) begin
            n_fail++;
            n_chk++;
            $display("FAIL R9 watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst         = 1'b1;
        start       = '0;
        period_ps   = 16'd3200;
        jitter_ps   = 16'd0;
        access_ps   = 20'(ACC);
        min_time_ps = {20'(tt[3]), 20'(tt[2]), 20'(tt[1]), 20'(tt[0])};
        min_cyc     = {8'(ff[3]), 8'(ff[2]), 8'(ff[1]), 8'(ff[0])};
        sb_q.push_back(model(3200, 0));                         // R6: latency 3
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(valid == 1'b0, "R13 valid in reset", valid, 0);
        chk(busy == 1'b0, "R13 busy in reset", busy, 0);
        chk(ready == '0, "R13 ready in reset", ready, 0);
        rst = 1'b0;
        wait_valid();
        chk(ready == 4'hF, "R13 ready after first result", ready, 15);

        apply(3333, 0, 1'b1);  wait_valid();                    // R2: 13500 -> 5
        apply(1875, 0, 1'b1);  wait_valid();                    // R2: exact 9375 -> 5
        apply(1875, 50, 1'b1); wait_valid();                    // R5: jitter
        apply(600, 0, 1'b1);   wait_valid();                    // R7: latency error
        apply(100, 200, 1'b1); wait_valid();                    // R5, R8: eff 1, saturate
        apply(10000, 0, 1'b1); wait_valid();                    // R3, R6: floor wins, clamp up

        // R9: change during a recalculation restarts it
        apply(3333, 0, 1'b0);
        repeat (10) @(negedge clk);
        apply(1875, 0, 1'b1);
        wait_valid();

        // R10: counts here are 8, 3, 1, 8
        strobe_run(0, 8, "R10 timer entry 0");
        strobe_run(2, 1, "R10 timer entry 2");
        chk(ready[1] == 1'b1, "R10 untouched timer", ready[1], 1);

        // R11: restrobe after three clocks restarts from the full count
        @(negedge clk);
        start[0] = 1'b1;
        @(negedge clk);
        start[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk(ready[0] == 1'b0, "R11 before restrobe", ready[0], 0);
        strobe_run(0, 8, "R11 restarted timer");

        // R12: strobe while stale is ignored
        apply(1875, 50, 1'b1);
        start[2] = 1'b1;
        @(negedge clk);
        start[2] = 1'b0;
        chk(ready == '0, "R12 ready low while stale", ready, 0);
        while (!valid) @(negedge clk);
        chk(ready == 4'hF, "R12 all ready at valid", ready, 15);
        @(negedge clk);

        chk(sb_q.size() == 0, "R9 all results seen", sb_q.size(), 0);
        done_f = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule